// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Write Modes

This block is a single storage array reached through two fully independent ports. Each port has its own clock, synchronous active-low reset, access enable, write strobe, address, write data and read data. Reads and writes happen on the rising edge of the port clock. The read result is always registered, so an access presented on one edge shows its data after that edge.

Each port is built with one of three write behaviours, which set what its read output shows in a cycle where it writes. One behaviour shows the incoming data. One shows the word that is being overwritten. One leaves the output as it was. Each port can also be built with a second output stage. That stage has its own load enable and adds one cycle of read latency, so the path can close at a higher clock rate.

When both ports run from one clock (the `SHARED_CLK` build option), accesses that meet at one address behave in a defined way. A port that reads a word the other port is writing gets the word's earlier contents. If both ports write the same word in the same cycle, port A's data is kept.

Top module: `dpram_tdp`

## Requirements
- R1: With enable high and write low, a port's first output stage shows the word at the presented address after the next clock edge. Without the second stage, this is the port output.
- R2: A port in write-new mode (mode code 0) shows its own write data on its output after a write cycle.
- R3: A port in write-old mode (mode code 1) shows the word's earlier contents after a write cycle, and the new data is stored.
- R4: A port in write-hold mode (mode code 2) keeps its output unchanged across a write cycle, and the new data is stored.
- R5: With the second output stage built in, the port output takes the first stage's value on an edge where the stage enable is high, and holds its value where the enable is low, giving one more cycle of read latency.
- R6: A low reset at a clock edge clears that port's output stages to zero. Stored words are kept.
- R7: With enable low, a port neither writes nor changes its first output stage, whatever the write strobe, address and data are.
- R8: With a shared clock, when both ports write the same address in the same cycle, port A's data is the one stored.
- R9: With a shared clock, a port that reads an address the other port writes in the same cycle gets the earlier contents. The new word can be read from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write strobe |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| regce_a | input | 1 | Port A second-stage load enable |
| dout_a | output | DATA_W | Port A read data |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write strobe |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| regce_b | input | 1 | Port B second-stage load enable |
| dout_b | output | DATA_W | Port B read data |

## Verification
The same-address collision check assumes that both ports are clocked by one clock, and it watches only port A's clock. The bench therefore drives both ports of both instances from a single clock. The per-port checks assume that a word is read only after it has been written, because unwritten words hold no defined value. The stimulus fills every address through port A, with the output comparisons switched off, before any checked read takes place. Random addresses then cover the whole filled range, so same-address meetings in any mode pairing occur freely, next to directed collision cases.

// File: rtl/dpram_pkg.sv
// Shared types for the dual-port RAM.
// Assumes nothing beyond a standard SystemVerilog elaborator.
package dpram_pkg;

    // Output behaviour of a port in a cycle where it writes
    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,  // output shows the incoming data
        WM_READ_FIRST  = 2'd1,  // output shows the overwritten word
        WM_NO_CHANGE   = 2'd2   // output keeps its previous value
    } wmode_e;

endpackage

// File: rtl/dpram_bank.sv
// One storage bank, written from a single clock, with two combinational read taps.
// Every bank word carries a freshness flag. Comparing it with the peer bank's
// flag tells which bank wrote the word last.
// Assumes: contents and flags are undefined until the word is first written.
module dpram_bank #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 6,
    parameter bit WRITER_IS_A = 1'b1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              peer_flag,
    input  logic [ADDR_W-1:0] rd_addr0,
    input  logic [ADDR_W-1:0] rd_addr1,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1,
    output logic              rd_flag0,
    output logic              rd_flag1
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DEPTH-1:0]  newer;

    // Store the word and mark this bank as the latest writer of it
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
            newer[waddr] <= WRITER_IS_A ? ~peer_flag : peer_flag;
        end
    end

    // Read taps for both ports
    assign rd_data0 = cells[rd_addr0];
    assign rd_data1 = cells[rd_addr1];
    assign rd_flag0 = newer[rd_addr0];
    assign rd_flag1 = newer[rd_addr1];

endmodule

// File: rtl/dpram_port.sv
// Read path of one port: a first output stage that follows the selected write
// mode, then an optional second stage with its own load enable.
// Assumes: mem_word is the pre-edge content at the port address.
module dpram_port
    import dpram_pkg::*;
#(
    parameter int     DATA_W  = 16,
    parameter wmode_e MODE    = WM_READ_FIRST,
    parameter bit     OUT_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_word,
    input  logic              regce,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] lat;
    logic [DATA_W-1:0] wr_view;

    // Value shown by the first stage in a write cycle, picked by mode
    generate
        case (MODE)
            WM_WRITE_FIRST: begin : g_wf
                assign wr_view = wdata;
                assert_write_new_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    (en && we) |=> (lat == $past(wdata)));
            end
            WM_READ_FIRST: begin : g_rf
                assign wr_view = mem_word;
                assert_write_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    (en && we) |=> (lat == $past(mem_word)));
            end
            default: begin : g_nc
                assign wr_view = lat;
                assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (en && we) |=> $stable(lat));
            end
        endcase
    endgenerate

    // First stage: registered read, mode-dependent view on writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat <= '0;
        end else if (en) begin
            lat <= we ? wr_view : mem_word;
        end
    end

    // Optional second stage
    generate
        if (OUT_REG) begin : g_oreg
            logic [DATA_W-1:0] oreg;
            // Second stage: load on enable, clear on reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    oreg <= '0;
                end else if (regce) begin
                    oreg <= lat;
                end
            end
            assign dout = oreg;
            assert_oreg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !regce |=> $stable(dout));
            assert_oreg_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
                regce |=> (dout == $past(lat)));
        end else begin : g_direct
            logic unused_regce;
            assign unused_regce = regce;
            assign dout = lat;
        end
    endgenerate

    assert_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we) |=> (lat == $past(mem_word)));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(lat));
    assert_reset_clear_R6: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));

endmodule

// File: rtl/dpram_tdp.sv
// Dual-port RAM top. There are two banks, one written by each port clock.
// Per-word freshness flags pick which bank holds the live word, so no storage
// element has two clock domains writing it.
// Assumes: with SHARED_CLK set, clk_a and clk_b are the same clock. Only then
// is the port-B write suppressed on a same-address double write.
module dpram_tdp
    import dpram_pkg::*;
#(
    parameter int     DATA_W     = 16,
    parameter int     ADDR_W     = 6,
    parameter wmode_e MODE_A     = WM_READ_FIRST,
    parameter wmode_e MODE_B     = WM_WRITE_FIRST,
    parameter bit     OUT_REG_A  = 1'b0,
    parameter bit     OUT_REG_B  = 1'b1,
    parameter bit     SHARED_CLK = 1'b1
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              en_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] din_a,
    input  logic              regce_a,
    output logic [DATA_W-1:0] dout_a,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              en_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din_b,
    input  logic              regce_b,
    output logic [DATA_W-1:0] dout_b
);
    logic [DATA_W-1:0] bank_a_at_a, bank_a_at_b, bank_b_at_a, bank_b_at_b;
    logic              flag_a_at_a, flag_a_at_b, flag_b_at_a, flag_b_at_b;
    logic              wr_a, wr_b, b_blocked;
    logic [DATA_W-1:0] word_at_a, word_at_b;

    assign wr_a = en_a & we_a;

    // Same-address double write arbitration, meaningful only on one clock
    generate
        if (SHARED_CLK) begin : g_arb
            assign b_blocked = wr_a & en_b & we_b & (addr_a == addr_b);
            assert_dual_write_a_wins_R8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
                (en_a && we_a && en_b && we_b && (addr_a == addr_b)) |=>
                ((u_bank_a.cells[$past(addr_a)] == $past(din_a)) &&
                 (u_bank_a.newer[$past(addr_a)] != u_bank_b.newer[$past(addr_a)])));
        end else begin : g_no_arb
            assign b_blocked = 1'b0;
        end
    endgenerate

    assign wr_b = en_b & we_b & ~b_blocked;

    dpram_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WRITER_IS_A(1'b1)) u_bank_a (
        .clk      (clk_a),
        .we       (wr_a),
        .waddr    (addr_a),
        .wdata    (din_a),
        .peer_flag(flag_b_at_a),
        .rd_addr0 (addr_a),
        .rd_addr1 (addr_b),
        .rd_data0 (bank_a_at_a),
        .rd_data1 (bank_a_at_b),
        .rd_flag0 (flag_a_at_a),
        .rd_flag1 (flag_a_at_b)
    );

    dpram_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WRITER_IS_A(1'b0)) u_bank_b (
        .clk      (clk_b),
        .we       (wr_b),
        .waddr    (addr_b),
        .wdata    (din_b),
        .peer_flag(flag_a_at_b),
        .rd_addr0 (addr_a),
        .rd_addr1 (addr_b),
        .rd_data0 (bank_b_at_a),
        .rd_data1 (bank_b_at_b),
        .rd_flag0 (flag_b_at_a),
        .rd_flag1 (flag_b_at_b)
    );

    // Live word per port: bank A holds it when the flags differ
    assign word_at_a = (flag_a_at_a != flag_b_at_a) ? bank_a_at_a : bank_b_at_a;
    assign word_at_b = (flag_a_at_b != flag_b_at_b) ? bank_a_at_b : bank_b_at_b;

    dpram_port #(.DATA_W(DATA_W), .MODE(MODE_A), .OUT_REG(OUT_REG_A)) u_port_a (
        .clk     (clk_a),
        .rst_n   (rst_a_n),
        .en      (en_a),
        .we      (we_a),
        .wdata   (din_a),
        .mem_word(word_at_a),
        .regce   (regce_a),
        .dout    (dout_a)
    );

    dpram_port #(.DATA_W(DATA_W), .MODE(MODE_B), .OUT_REG(OUT_REG_B)) u_port_b (
        .clk     (clk_b),
        .rst_n   (rst_b_n),
        .en      (en_b),
        .we      (we_b),
        .wdata   (din_b),
        .mem_word(word_at_b),
        .regce   (regce_b),
        .dout    (dout_b)
    );

endmodule

// File: tb/dpram_tdp_bench.sv
// Bench: two instances on one 125 MHz clock, covering all three write modes
// and both output-stage options, checked against a cycle model.
module dpram_tdp_bench;
    import dpram_pkg::*;

    localparam int DW = 16;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rstn  [2];
    logic          en    [2];
    logic          we    [2];
    logic [AW-1:0] addr  [2];
    logic [DW-1:0] din   [2];
    logic          regce [2];
    logic [DW-1:0] dout  [4];

    // model state; index k: 0 = inst1 A, 1 = inst1 B, 2 = inst2 A, 3 = inst2 B
    logic [DW-1:0] mm    [DEPTH];
    logic [DW-1:0] m_lat [4];
    logic [DW-1:0] m_out [4];
    logic [DW-1:0] exp_v [4];
    int            mode_k [4] = '{1, 0, 2, 1};  // 0 write-new, 1 write-old, 2 hold
    bit            reg_k  [4] = '{1'b0, 1'b1, 1'b1, 1'b0};

    int  checks = 0;
    int  errors = 0;
    bit  chk_on = 1'b0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    dpram_tdp #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(WM_READ_FIRST), .MODE_B(WM_WRITE_FIRST),
                .OUT_REG_A(1'b0), .OUT_REG_B(1'b1), .SHARED_CLK(1'b1)) u_dpram_tdp (
        .clk_a(clk), .rst_a_n(rstn[0]), .en_a(en[0]), .we_a(we[0]), .addr_a(addr[0]),
        .din_a(din[0]), .regce_a(regce[0]), .dout_a(dout[0]),
        .clk_b(clk), .rst_b_n(rstn[1]), .en_b(en[1]), .we_b(we[1]), .addr_b(addr[1]),
        .din_b(din[1]), .regce_b(regce[1]), .dout_b(dout[1])
    );

    dpram_tdp #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(WM_NO_CHANGE), .MODE_B(WM_READ_FIRST),
                .OUT_REG_A(1'b1), .OUT_REG_B(1'b0), .SHARED_CLK(1'b1)) u_dpram_tdp_alt (
        .clk_a(clk), .rst_a_n(rstn[0]), .en_a(en[0]), .we_a(we[0]), .addr_a(addr[0]),
        .din_a(din[0]), .regce_a(regce[0]), .dout_a(dout[2]),
        .clk_b(clk), .rst_b_n(rstn[1]), .en_b(en[1]), .we_b(we[1]), .addr_b(addr[1]),
        .din_b(din[1]), .regce_b(regce[1]), .dout_b(dout[3])
    );

    // One edge of the model, computed from the requirements
    task automatic step_model();
        for (int k = 0; k < 4; k++) begin
            int p = k % 2;
            logic [DW-1:0] nl, no;
            if (!rstn[p]) begin
                nl = '0;
                no = '0;
            end else begin
                no = regce[p] ? m_lat[k] : m_out[k];
                nl = m_lat[k];
                if (en[p]) begin
                    if (!we[p]) nl = mm[addr[p]];
                    else if (mode_k[k] == 0) nl = din[p];
                    else if (mode_k[k] == 1) nl = mm[addr[p]];
                end
            end
            m_lat[k] = nl;
            m_out[k] = no;
            exp_v[k] = reg_k[k] ? no : nl;
        end
        if (en[1] && we[1]) mm[addr[1]] = din[1];
        if (en[0] && we[0]) mm[addr[0]] = din[0];  // R8: port A wins
    endtask

    task automatic cyc(input string tag);
        step_model();
        @(posedge clk);
        @(negedge clk);
        if (chk_on) begin
            for (int k = 0; k < 4; k++) begin
                checks++;
                if (dout[k] !== exp_v[k]) begin
                    errors++;
                    $display("FAIL %s out%0d actual=%h expected=%h", tag, k, dout[k], exp_v[k]);
                end
            end
        end
    endtask

    task automatic idle();
        for (int p = 0; p < 2; p++) begin
            rstn[p] = 1'b1; en[p] = 1'b0; we[p] = 1'b0;
            addr[p] = '0; din[p] = '0; regce[p] = 1'b1;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mm[i] = '0;
        for (int k = 0; k < 4; k++) begin m_lat[k] = '0; m_out[k] = '0; end
        idle();
        rstn[0] = 1'b0; rstn[1] = 1'b0;
        chk_on = 1'b1;
        cyc("R6 reset state");
        cyc("R6 reset state");

        // fill every word through port A, unchecked
        chk_on = 1'b0;
        idle();
        for (int i = 0; i < DEPTH; i++) begin
            en[0] = 1'b1; we[0] = 1'b1; addr[0] = AW'(i);
            din[0] = DW'(i * 16'h0101) ^ 16'h5A00;
            cyc("fill");
        end
        idle();
        rstn[0] = 1'b0; rstn[1] = 1'b0;
        cyc("fill");
        idle();
        chk_on = 1'b1;

        // R1 plain reads
        en[0] = 1'b1; addr[0] = 6'd5; en[1] = 1'b1; addr[1] = 6'd9;
        cyc("R1");
        idle();
        cyc("R1"); cyc("R1");

        // R2 R3 R4 write view per mode
        en[0] = 1'b1; we[0] = 1'b1; addr[0] = 6'd10; din[0] = 16'hA10A;
        en[1] = 1'b1; we[1] = 1'b1; addr[1] = 6'd11; din[1] = 16'hB11B;
        cyc("R2 R3 R4");
        idle();
        cyc("R2 R3 R4"); cyc("R2 R3 R4");
        en[0] = 1'b1; addr[0] = 6'd10; en[1] = 1'b1; addr[1] = 6'd11;
        cyc("R3 R4 stored");
        idle();
        cyc("R3 R4 stored");

        // R5 second stage enable
        en[0] = 1'b1; addr[0] = 6'd12; en[1] = 1'b1; addr[1] = 6'd12;
        regce[0] = 1'b0; regce[1] = 1'b0;
        cyc("R5"); cyc("R5");
        regce[0] = 1'b1; regce[1] = 1'b1;
        cyc("R5"); cyc("R5");

        // R7 disabled port ignores write
        idle();
        we[0] = 1'b1; addr[0] = 6'd13; din[0] = 16'hDEAD;
        we[1] = 1'b1; addr[1] = 6'd14; din[1] = 16'hBEEF;
        cyc("R7"); cyc("R7");
        idle();
        en[0] = 1'b1; addr[0] = 6'd13; en[1] = 1'b1; addr[1] = 6'd14;
        cyc("R7"); cyc("R7");

        // R8 same-address double write
        en[0] = 1'b1; we[0] = 1'b1; addr[0] = 6'd20; din[0] = 16'h1111;
        en[1] = 1'b1; we[1] = 1'b1; addr[1] = 6'd20; din[1] = 16'h2222;
        cyc("R8");
        idle();
        en[0] = 1'b1; addr[0] = 6'd20; en[1] = 1'b1; addr[1] = 6'd20;
        cyc("R8"); cyc("R8");

        // R9 read during other port's write
        idle();
        en[0] = 1'b1; we[0] = 1'b1; addr[0] = 6'd30; din[0] = 16'h3333;
        en[1] = 1'b1; addr[1] = 6'd30;
        cyc("R9");
        idle();
        en[1] = 1'b1; addr[1] = 6'd30;
        cyc("R9"); cyc("R9");

        // R6 mid-run reset keeps contents
        idle();
        en[0] = 1'b1; addr[0] = 6'd5; en[1] = 1'b1; addr[1] = 6'd5;
        cyc("R6"); cyc("R6");
        rstn[0] = 1'b0; rstn[1] = 1'b0;
        cyc("R6 cleared");
        rstn[0] = 1'b1; rstn[1] = 1'b1;
        addr[0] = 6'd20; addr[1] = 6'd10;
        cyc("R6 kept"); cyc("R6 kept");

        // random traffic, fixed seed
        void'($urandom(32'd2024));
        for (int n = 0; n < 500; n++) begin
            for (int p = 0; p < 2; p++) begin
                rstn[p]  = ($urandom % 40) != 0;
                en[p]    = ($urandom % 4) != 0;
                we[p]    = ($urandom % 2) != 0;
                addr[p]  = AW'($urandom % 8) + (($urandom % 3 == 0) ? AW'(0) : AW'($urandom % DEPTH));
                din[p]   = DW'($urandom);
                regce[p] = ($urandom % 4) != 0;
            end
            cyc("R1 R8 R9 random");
        end
        summary();
    end

endmodule